// File: doc/BRIEF.md
# Clock-Control Register Bank with Access-Error Flags

This block holds the software-visible configuration of a clock generator built from a PLL and a set of clock dividers. A simple single-cycle bus reads and writes four 32-bit words: a control word with the multiplier and input-divide fields, a divider word, a status word and a write-protect word. Read data and the bus-error response are returned combinationally in the same cycle as the access. Accepted writes take effect at the next clock edge. The stored control and divider values are also driven out to the clock generator.

The block sorts the PLL status inputs into one of four phases. It refuses register writes that are unsafe in the current phase or that hit a protected or non-existent location. Each refused access sets a sticky status flag that software clears by writing one to it. Protection and address faults also return a bus error. The status word also reflects a 2-bit oscillator watchdog input as a read-only fault bit and fault code.

The phase is held in a state machine with four states: `PH_UNLOCKED`, `PH_LOCKING`, `PH_ALIGNING` and `PH_LOCKED`. The next state is chosen from the status inputs in fixed priority, whatever the current state:
- `pll_locking` high leads to `PH_LOCKING`.
- Otherwise, `pll_locked` and `pll_aligning` both high lead to `PH_ALIGNING`.
- Otherwise, `pll_locked` alone leads to `PH_LOCKED`.
- Otherwise the next state is `PH_UNLOCKED`.

Reset enters `PH_UNLOCKED`. Every transition is taken one clock edge after the inputs change.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, the registers read as follows: control word (byte address 0x00) = 0x0000_0110, divider word (0x04) = 0x0000_0421, status word (0x08) = 0, and write-protect word (0x0C) = 0. `cfg_ctl` is 0x0110 and `cfg_div` is 0x0000_0421. These status and protect values hold while `wd_stat` is 0.
- R2: In the unlocked, locking and locked phases, a write to the divider word is applied. A later read returns the new value, and `cfg_div` shows it one edge after the access. The control word keeps bits 13:0, with the multiplier in 7:0 and the input divide in 13:8, and reads back zero-extended.
- R3: A write to the divider word in the aligning phase is not applied. It sets status bit 20 and does not raise `bus_err`.
- R4: A write to the control word in the locking phase is not applied. It sets status bit 19 and does not raise `bus_err`. A control-word write in the aligning phase is applied.
- R5: While bit 0 of the write-protect word is 1, a write to the control or divider word is dropped. The access raises `bus_err` in the same cycle and sets status bit 17. Reads, status writes and write-protect writes stay allowed.
- R6: Any access whose address has nonzero bits 1:0, or whose word index is 4 or more, raises `bus_err`, returns read data 0, and sets status bit 16.
- R7: Status bits 20, 19, 17 and 16 stay set until a status-word write carries a 1 in that bit position. A 0 in the written data leaves the bit unchanged.
- R8: Status bit 15 reads 1 when `wd_stat` is nonzero. Bits 14:12 read the fault code {0, `wd_stat`}, where code 1 means no input clock. Writes do not change these bits.
- R9: The phase used to judge an access is the one registered from the status inputs at the previous edge. Locking takes priority over aligning, aligning over locked, and locked over unlocked.
- R10: One access sets at most one flag. An address fault wins over a protection fault, and a protection fault wins over a phase fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Bus-error response, same cycle |
| pll_locking | input | 1 | PLL is acquiring lock |
| pll_locked | input | 1 | PLL is locked |
| pll_aligning | input | 1 | Output clocks are being realigned |
| wd_stat | input | 2 | Oscillator watchdog status |
| cfg_ctl | output | 14 | Applied multiplier and input-divide fields |
| cfg_div | output | 32 | Applied divider word |

## Verification
A phase register that lags or decodes the wrong priority shows up at the ports on the first write after the status inputs change. Such a write is wrongly applied on `cfg_div` or `cfg_ctl`, or wrongly refused, and the status read in the next access confirms it. A flag bit that loses its sticky or write-one-to-clear behaviour appears on the next status read. A wrong violation priority leaves extra flag bits set, which the same read exposes. Protection and address faults are visible at once on `bus_err` in the cycle of the access.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    typedef enum logic [1:0] {
        PH_UNLOCKED,
        PH_LOCKING,
        PH_ALIGNING,
        PH_LOCKED
    } pll_phase_e;

    typedef enum logic [2:0] {
        V_NONE,
        V_ADDR,
        V_PROT,
        V_DIVW,
        V_MULW
    } viol_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_DIV,
        SEL_STAT,
        SEL_PROT
    } reg_sel_e;

    localparam int NUM_REGS = 4;
    localparam int IDX_CTL  = 0;
    localparam int IDX_DIV  = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_PROT = 3;

    localparam int NUM_FLAGS    = 4;
    localparam int BIT_DIVERR   = 20;
    localparam int BIT_MULERR   = 19;
    localparam int BIT_PROTERR  = 17;
    localparam int BIT_ADDRERR  = 16;
    localparam int BIT_WDFAULT  = 15;
    localparam int BIT_WDCODE_L = 12;

endpackage

// File: rtl/clkctl_phase_fsm.sv
module clkctl_phase_fsm
    import clkctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       locking,
    input  logic       locked,
    input  logic       aligning,
    output pll_phase_e phase,
    output logic       in_locking,
    output logic       in_aligning
);

    pll_phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_UNLOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        if (locking)                state_d = PH_LOCKING;
        else if (locked && aligning) state_d = PH_ALIGNING;
        else if (locked)            state_d = PH_LOCKED;
        else                        state_d = PH_UNLOCKED;
    end

    always_comb begin
        phase       = state_q;
        in_locking  = 1'b0;
        in_aligning = 1'b0;
        unique case (state_q)
            PH_UNLOCKED: ;
            PH_LOCKING:  in_locking  = 1'b1;
            PH_ALIGNING: in_aligning = 1'b1;
            PH_LOCKED:   ;
            default:     ;
        endcase
    end

    AST_LOCKING_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        locking |=> (phase == PH_LOCKING)) else $error("phase priority"); // R9

    AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!locking && !locked) |=> (phase == PH_UNLOCKED)) else $error("phase idle"); // R9

endmodule

// File: rtl/clkctl_access_chk.sv
module clkctl_access_chk
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic              prot_en,
    input  logic              in_locking,
    input  logic              in_aligning,
    output reg_sel_e          sel,
    output viol_e             viol
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             misaligned;
    logic             unmapped;

    assign idx        = addr[ADDR_W-1:2];
    assign misaligned = |addr[1:0];
    assign unmapped   = (idx >= IDX_W'(NUM_REGS));

    always_comb begin
        sel  = SEL_NONE;
        viol = V_NONE;
        if (valid) begin
            if (misaligned || unmapped) begin
                viol = V_ADDR;
            end else begin
                unique case (idx)
                    IDX_W'(IDX_CTL):  sel = SEL_CTL;
                    IDX_W'(IDX_DIV):  sel = SEL_DIV;
                    IDX_W'(IDX_STAT): sel = SEL_STAT;
                    default:          sel = SEL_PROT;
                endcase
                if (write) begin
                    if ((sel == SEL_CTL || sel == SEL_DIV) && prot_en)
                        viol = V_PROT;
                    else if (sel == SEL_DIV && in_aligning)
                        viol = V_DIVW;
                    else if (sel == SEL_CTL && in_locking)
                        viol = V_MULW;
                end
            end
        end
    end

endmodule

// File: rtl/clkctl_stat_flags.sv
module clkctl_stat_flags
    import clkctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_vec,
    input  logic [NUM_FLAGS-1:0] clr_vec,
    output logic [NUM_FLAGS-1:0] flags
);

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags[k] <= 1'b0;
            else if (set_vec[k]) flags[k] <= 1'b1;
            else if (clr_vec[k]) flags[k] <= 1'b0;
        end

        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_vec[k] && !clr_vec[k]) |=> $stable(flags[k])) else $error("sticky"); // R7

        AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[k] && !set_vec[k]) |=> !flags[k]) else $error("w1c"); // R7
    end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int          ADDR_W  = 6,
    parameter int          MULT_W  = 8,
    parameter int          IDIV_W  = 6,
    parameter logic [13:0] CTL_RST = 14'h0110,
    parameter logic [31:0] DIV_RST = 32'h0000_0421
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     bus_err,
    input  logic                     pll_locking,
    input  logic                     pll_locked,
    input  logic                     pll_aligning,
    input  logic [1:0]               wd_stat,
    output logic [MULT_W+IDIV_W-1:0] cfg_ctl,
    output logic [31:0]              cfg_div
);

    localparam int CTL_W = MULT_W + IDIV_W;

    pll_phase_e            phase;
    logic                  in_locking, in_aligning;
    reg_sel_e              sel;
    viol_e                 viol;
    logic                  prot_q;
    logic [CTL_W-1:0]      ctl_q;
    logic [31:0]           div_q;
    logic [NUM_FLAGS-1:0]  set_vec, clr_vec, flags;
    logic                  wr_ok;
    logic [31:0]           stat_word;

    clkctl_phase_fsm u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .locking    (pll_locking),
        .locked     (pll_locked),
        .aligning   (pll_aligning),
        .phase      (phase),
        .in_locking (in_locking),
        .in_aligning(in_aligning)
    );

    clkctl_access_chk #(.ADDR_W(ADDR_W)) u_chk (
        .valid      (bus_valid),
        .write      (bus_write),
        .addr       (bus_addr),
        .prot_en    (prot_q),
        .in_locking (in_locking),
        .in_aligning(in_aligning),
        .sel        (sel),
        .viol       (viol)
    );

    assign set_vec = {viol == V_DIVW, viol == V_MULW, viol == V_PROT, viol == V_ADDR};
    assign wr_ok   = bus_write && (viol == V_NONE);
    assign clr_vec = (wr_ok && sel == SEL_STAT)
                   ? {bus_wdata[BIT_DIVERR], bus_wdata[BIT_MULERR],
                      bus_wdata[BIT_PROTERR], bus_wdata[BIT_ADDRERR]}
                   : '0;

    clkctl_stat_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .flags  (flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RST[CTL_W-1:0];
            div_q  <= DIV_RST;
            prot_q <= 1'b0;
        end else if (wr_ok) begin
            unique case (sel)
                SEL_CTL:  ctl_q  <= bus_wdata[CTL_W-1:0];
                SEL_DIV:  div_q  <= bus_wdata;
                SEL_PROT: prot_q <= bus_wdata[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        stat_word = '0;
        stat_word[BIT_DIVERR]  = flags[3];
        stat_word[BIT_MULERR]  = flags[2];
        stat_word[BIT_PROTERR] = flags[1];
        stat_word[BIT_ADDRERR] = flags[0];
        stat_word[BIT_WDFAULT] = |wd_stat;
        stat_word[BIT_WDCODE_L +: 3] = {1'b0, wd_stat};
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTL:  bus_rdata = {{(32-CTL_W){1'b0}}, ctl_q};
            SEL_DIV:  bus_rdata = div_q;
            SEL_STAT: bus_rdata = stat_word;
            SEL_PROT: bus_rdata = {31'b0, prot_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign bus_err = (viol == V_ADDR) || (viol == V_PROT);
    assign cfg_ctl = ctl_q;
    assign cfg_div = div_q;

    AST_DIV_HELD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(4) && phase == PH_ALIGNING)
        |=> $stable(cfg_div)) else $error("div align"); // R3

    AST_CTL_HELD_LOCKING: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(0) && phase == PH_LOCKING)
        |=> $stable(cfg_ctl)) else $error("ctl locking"); // R4

    AST_PROT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && prot_q && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(4)))
        |=> ($stable(cfg_ctl) && $stable(cfg_div))) else $error("prot"); // R5

    AST_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && |bus_addr[1:0]) |-> bus_err) else $error("misaligned"); // R6

    AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_err) |=> (flags[1] || flags[0])) else $error("err flag"); // R6

endmodule

// File: tb/test_clkctl_regbank.sv
module test_clkctl_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        pll_locking = 1'b0, pll_locked = 1'b0, pll_aligning = 1'b0;
    logic [1:0]  wd_stat = 2'b00;
    logic [13:0] cfg_ctl;
    logic [31:0] cfg_div;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    localparam logic [5:0] A_CTL = 6'h00, A_DIV = 6'h04, A_STAT = 6'h08, A_PROT = 6'h0C;
    localparam logic [31:0] F_DIV = 32'h0010_0000, F_MUL = 32'h0008_0000,
                            F_PROT = 32'h0002_0000, F_ADDR = 32'h0001_0000;

    always #10 clk = ~clk;

    clkctl_regbank i_clkctl_regbank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .pll_locking(pll_locking), .pll_locked(pll_locked), .pll_aligning(pll_aligning),
        .wd_stat(wd_stat), .cfg_ctl(cfg_ctl), .cfg_div(cfg_div)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input bit wr, input logic [5:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        #5;
        rd = bus_rdata; er = bus_err;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic er;
        bus(1'b0, a, 32'h0, rd, er);
        chk(req, rd, exp);
        chk(req, {31'b0, er}, 32'h0);
    endtask

    task automatic wr_chk(input string req, input logic [5:0] a, input logic [31:0] d, input bit exp_err);
        logic [31:0] rd; logic er;
        bus(1'b1, a, d, rd, er);
        chk(req, {31'b0, er}, {31'b0, exp_err});
    endtask

    task automatic set_pll(input bit lk, input bit ld, input bit al);
        @(negedge clk);
        pll_locking = lk; pll_locked = ld; pll_aligning = al;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 cfg_ctl", {18'b0, cfg_ctl}, 32'h0110);
        chk("R1 cfg_div", cfg_div, 32'h0000_0421);
        rd_chk("R1 ctl", A_CTL, 32'h0000_0110);
        rd_chk("R1 div", A_DIV, 32'h0000_0421);
        rd_chk("R1 stat", A_STAT, 32'h0);
        rd_chk("R1 prot", A_PROT, 32'h0);
    endtask

    task automatic t_basic;
        wr_chk("R2 ctl wr", A_CTL, 32'hFFFF_2A33, 1'b0);
        chk("R2 cfg_ctl", {18'b0, cfg_ctl}, 32'h2A33);
        rd_chk("R2 ctl rd", A_CTL, 32'h0000_2A33);
        wr_chk("R2 div wr", A_DIV, 32'hDEAD_BEEF, 1'b0);
        chk("R2 cfg_div", cfg_div, 32'hDEAD_BEEF);
        rd_chk("R2 div rd", A_DIV, 32'hDEAD_BEEF);
    endtask

    task automatic t_locking;
        set_pll(1, 0, 0);
        wr_chk("R2 div locking", A_DIV, 32'h1234_5678, 1'b0);
        rd_chk("R2 div locking rd", A_DIV, 32'h1234_5678);
        wr_chk("R4 ctl locking", A_CTL, 32'h0000_0001, 1'b0);
        chk("R4 cfg_ctl held", {18'b0, cfg_ctl}, 32'h2A33);
        rd_chk("R4 stat", A_STAT, F_MUL);
    endtask

    task automatic t_align;
        set_pll(0, 1, 1);
        wr_chk("R3 div align", A_DIV, 32'h0000_0055, 1'b0);
        chk("R3 cfg_div held", cfg_div, 32'h1234_5678);
        rd_chk("R3 stat", A_STAT, F_DIV | F_MUL);
        wr_chk("R4 ctl align ok", A_CTL, 32'h0000_0333, 1'b0);
        chk("R4 cfg_ctl align", {18'b0, cfg_ctl}, 32'h0333);
        wr_chk("R7 w0", A_STAT, 32'h0, 1'b0);
        rd_chk("R7 w0 keeps", A_STAT, F_DIV | F_MUL);
        wr_chk("R7 w1 div", A_STAT, F_DIV, 1'b0);
        rd_chk("R7 only div cleared", A_STAT, F_MUL);
        wr_chk("R7 w1 mul", A_STAT, F_MUL, 1'b0);
        rd_chk("R7 all clear", A_STAT, 32'h0);
        set_pll(1, 1, 1);
        wr_chk("R9 locking over aligning", A_DIV, 32'hCAFE_0001, 1'b0);
        chk("R9 cfg_div", cfg_div, 32'hCAFE_0001);
        rd_chk("R9 stat", A_STAT, 32'h0);
    endtask

    task automatic t_prot;
        set_pll(0, 0, 0);
        wr_chk("R5 prot on", A_PROT, 32'h1, 1'b0);
        rd_chk("R5 prot rd", A_PROT, 32'h1);
        wr_chk("R5 div prot", A_DIV, 32'h1, 1'b1);
        chk("R5 cfg_div held", cfg_div, 32'hCAFE_0001);
        wr_chk("R5 ctl prot", A_CTL, 32'h1, 1'b1);
        chk("R5 cfg_ctl held", {18'b0, cfg_ctl}, 32'h0333);
        rd_chk("R5 read allowed", A_DIV, 32'hCAFE_0001);
        rd_chk("R5 stat", A_STAT, F_PROT);
        wr_chk("R5 stat clr allowed", A_STAT, F_PROT, 1'b0);
        set_pll(0, 1, 1);
        wr_chk("R10 prot over phase", A_DIV, 32'h7, 1'b1);
        rd_chk("R10 only prot flag", A_STAT, F_PROT);
        wr_chk("R7 clr prot", A_STAT, F_PROT, 1'b0);
        set_pll(0, 0, 0);
        wr_chk("R5 prot off", A_PROT, 32'h0, 1'b0);
    endtask

    task automatic t_addr;
        logic [31:0] rd; logic er;
        bus(1'b0, 6'h10, 32'h0, rd, er);
        chk("R6 unmapped err", {31'b0, er}, 32'h1);
        chk("R6 unmapped rdata", rd, 32'h0);
        bus(1'b0, 6'h05, 32'h0, rd, er);
        chk("R6 misaligned rd err", {31'b0, er}, 32'h1);
        chk("R6 misaligned rdata", rd, 32'h0);
        rd_chk("R6 stat", A_STAT, F_ADDR);
        wr_chk("R7 clr addr", A_STAT, F_ADDR, 1'b0);
        set_pll(0, 1, 1);
        wr_chk("R10 addr over phase", 6'h06, 32'h9, 1'b1);
        chk("R6 cfg_div held", cfg_div, 32'hCAFE_0001);
        rd_chk("R10 only addr flag", A_STAT, F_ADDR);
        wr_chk("R7 clr addr 2", A_STAT, F_ADDR, 1'b0);
        set_pll(0, 0, 0);
    endtask

    task automatic t_wd;
        wd_stat = 2'b01;
        rd_chk("R8 no input clock", A_STAT, 32'h0000_9000);
        wd_stat = 2'b10;
        rd_chk("R8 code 2", A_STAT, 32'h0000_A000);
        wr_chk("R8 write ro", A_STAT, 32'h0003_F000, 1'b0);
        rd_chk("R8 ro unchanged", A_STAT, 32'h0000_A000);
        wd_stat = 2'b00;
        rd_chk("R8 cleared", A_STAT, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_locking();
        t_align();
        t_prot();
        t_addr();
        t_wd();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule